// File: doc/BRIEF.md
# Dual-Path Variable-Length Instruction Decoder

This block walks a fetched instruction line and splits it into variable-length instructions. It delivers them in program order on two output slots that feed a two-wide issue stage. The length of an instruction is known only once its first byte has been examined. The block keeps a small learned table with one entry per byte offset of the line. An entry holds a "known start" marker and the length recorded for that start.

An instruction whose start offset carries no marker goes through a slow path. The slow path is exact and non-speculative: it inspects the length bits one at a time, takes three cycles per instruction, and records the marker and length when it finishes. An instruction whose start is marked, and whose recorded length still matches its first byte, goes through a fast path. The fast path trusts the recorded boundary and can issue that instruction together with the one that follows it in the same cycle. A marked start whose recorded length disagrees with the byte now at that offset has its marker cleared and is decoded again on the slow path.

To use the block, present a line on `line_data` and pulse `start` while the block is idle. Then consume the slots with `out_ready`. A second walk over the same line runs mostly on the fast path. `flush` forgets everything the block has learned.

Top module: `idec_dual`

## Requirements
- R1: Byte i of the line is `line_data[8i+7:8i]`. The length is set by the low two bits of an instruction's first byte: 2 gives 2 bytes, 3 gives 3 bytes, and 0 or 1 give 1 byte. A slot's bytes sit in program order from bits [7:0] upward, bytes beyond the length read as zero, and the slot's offset is the first byte's index in the line.
- R2: After reset the block is idle, with `busy` low and both slots invalid. A `start` pulse while idle begins a walk at offset 0, and `busy` stays high until the walk has passed the end of the line. A `start` while busy has no effect.
- R3: An instruction whose start is unmarked is issued alone on slot 0 with `o_fast0` low. With `out_ready` held high, it appears exactly three cycles after the previous output or after the cycle in which `start` was taken.
- R4: Each slow-path completion marks its start offset and records its length, so the same instruction at the same offset takes the fast path (`o_fast0` high) on a later walk.
- R5: When a marked, consistent instruction is followed by another marked, consistent instruction, both issue in the same cycle, and slot 1 begins at slot 0's offset plus slot 0's length.
- R6: Slot 1 is valid only when slot 0 is valid and slot 0 came from the fast path; slot 0 always holds the earlier instruction.
- R7: When a fast slot-0 instruction is followed by an unmarked or inconsistent start, only slot 0 issues that cycle, and the follower then goes through the slow path.
- R8: A marked start whose recorded length differs from the length its current first byte encodes produces no fast output. Its marker is cleared, and it is re-decoded on the slow path with its current length, which is then recorded.
- R9: While slot 0 is valid and `out_ready` is low, both slots keep every output value and the walk does not advance.
- R10: A `flush` pulse clears every marker, so the next walk decodes every instruction on the slow path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears all learned markers |
| start | input | 1 | Begins a walk of the line at offset 0 when idle |
| line_data | input | 8*LINE_BYTES | Instruction line, byte i at bits [8i+7:8i] |
| busy | output | 1 | A walk is in progress |
| out_ready | input | 1 | Consumer accepts all valid slots this cycle |
| o_v0 | output | 1 | Slot 0 valid |
| o_v1 | output | 1 | Slot 1 valid |
| o_fast0 | output | 1 | Slot 0 was produced by the fast path |
| o_off0 | output | $clog2(LINE_BYTES) | Slot 0 start offset |
| o_off1 | output | $clog2(LINE_BYTES) | Slot 1 start offset |
| o_len0 | output | 2 | Slot 0 length in bytes |
| o_len1 | output | 2 | Slot 1 length in bytes |
| o_ins0 | output | 24 | Slot 0 instruction bytes |
| o_ins1 | output | 24 | Slot 1 instruction bytes |

## Verification
The properties assume that `line_data` stays unchanged for the whole of a walk. They also assume that the instruction lengths in a line add up exactly to the line size, so no instruction runs past the last byte. Otherwise a slot-1 offset could wrap, and a length could be judged against a byte that changed mid-walk. The stimulus builds every line from a list of lengths whose sum is the line size, and it changes `line_data` or pulses `flush` only while `busy` is low. Lines are replayed with altered lengths at already-learned offsets, which drives both slot-0 and slot-1 disagreements.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int MAX_LEN = 3;
  localparam int INS_W   = 8 * MAX_LEN;

  // Length in bytes encoded by the two low bits of a first byte.
  function automatic logic [1:0] len_of(input logic [1:0] code);
    case (code)
      2'd2:    return 2'd2;
      2'd3:    return 2'd3;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/idec_marks.sv
// Learned boundary table: one start marker plus recorded length per byte offset.
// Kept in flops so a flush can clear the whole table in a single cycle.
module idec_marks #(
  parameter  int ENTRIES = 16,
  localparam int IW      = $clog2(ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr_all,
  input  logic                   set_en,
  input  logic [IW-1:0]          set_idx,
  input  logic [1:0]             set_len,
  input  logic                   clr_en,
  input  logic [IW-1:0]          clr_idx,
  output logic [ENTRIES-1:0]     mark,
  output logic [2*ENTRIES-1:0]   mlen
);
  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      mark <= '0;
    end else begin
      if (set_en) mark[set_idx] <= 1'b1;
      if (clr_en) mark[clr_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mlen <= '0;
    end else if (set_en) begin
      mlen[int'(set_idx)*2 +: 2] <= set_len;
    end
  end
endmodule

// File: rtl/idec_slow.sv
// Exact length finder: latches one length bit per cycle, result ready on the
// third cycle of an instruction and held until the output stage takes it.
module idec_slow import idec_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       finish,
  input  logic [1:0] code,
  output logic       busy,
  output logic       done,
  output logic [1:0] len
);
  logic [1:0] step;
  logic       bit_lo, bit_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= 2'd0;
      bit_lo <= 1'b0;
      bit_hi <= 1'b0;
    end else begin
      case (step)
        2'd0: if (start) begin
          step   <= 2'd1;
          bit_lo <= code[0];
        end
        2'd1: begin
          step   <= 2'd2;
          bit_hi <= code[1];
        end
        2'd2: if (finish) step <= 2'd0;
        default: step <= 2'd0;
      endcase
    end
  end

  assign busy = (step != 2'd0);
  assign done = (step == 2'd2);
  assign len  = len_of({bit_hi, bit_lo});
endmodule

// File: rtl/idec_fast.sv
// Two-wide boundary lookup using recorded lengths; purely combinational.
module idec_fast import idec_pkg::*; #(
  parameter  int N  = 16,
  localparam int IW = $clog2(N),
  localparam int PW = IW + 1
) (
  input  logic [8*N-1:0]   line,
  input  logic [PW-1:0]    ptr,
  input  logic [N-1:0]     mark,
  input  logic [2*N-1:0]   mlen,
  input  logic [1:0]       slen,
  output logic [1:0]       code0,
  output logic             m0,
  output logic             h0,
  output logic             h1,
  output logic             x1,
  output logic [1:0]       len0,
  output logic [1:0]       len1,
  output logic [PW-1:0]    q,
  output logic [PW-1:0]    nxt,
  output logic [INS_W-1:0] ins0,
  output logic [INS_W-1:0] ins1,
  output logic [INS_W-1:0] ins_s
);
  function automatic logic [7:0] byte_at(input logic [8*N-1:0] ln, input logic [PW-1:0] idx);
    if (idx < PW'(N)) return ln[int'(idx)*8 +: 8];
    return 8'h00;
  endfunction

  function automatic logic [INS_W-1:0] ins_at(input logic [8*N-1:0] ln,
                                              input logic [PW-1:0] off,
                                              input logic [1:0] len);
    logic [INS_W-1:0] r;
    r = '0;
    for (int k = 0; k < MAX_LEN; k++) begin
      if (k < int'(len)) r[k*8 +: 8] = byte_at(ln, off + PW'(k));
    end
    return r;
  endfunction

  logic [7:0]    b0, b1;
  logic [IW-1:0] idx0, idx1;
  logic          m1, in1;
  logic [1:0]    rec0, rec1;

  assign b0    = byte_at(line, ptr);
  assign code0 = b0[1:0];
  assign idx0  = ptr[IW-1:0];
  assign m0    = (ptr < PW'(N)) && mark[idx0];
  assign len0  = len_of(b0[1:0]);
  assign rec0  = mlen[int'(idx0)*2 +: 2];
  assign h0    = m0 && (rec0 == len0);

  assign q     = ptr + PW'(len0);
  assign b1    = byte_at(line, q);
  assign idx1  = q[IW-1:0];
  assign in1   = (q < PW'(N));
  assign m1    = in1 && mark[idx1];
  assign len1  = len_of(b1[1:0]);
  assign rec1  = mlen[int'(idx1)*2 +: 2];
  assign h1    = h0 && m1 && (rec1 == len1);
  assign x1    = h0 && m1 && (rec1 != len1);
  assign nxt   = q + PW'(len1);

  assign ins0  = ins_at(line, ptr, len0);
  assign ins1  = ins_at(line, q, len1);
  assign ins_s = ins_at(line, ptr, slen);
endmodule

// File: rtl/idec_dual.sv
module idec_dual import idec_pkg::*; #(
  parameter  int LINE_BYTES = 16,
  localparam int IW = $clog2(LINE_BYTES),
  localparam int PW = IW + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic                    start,
  input  logic [8*LINE_BYTES-1:0] line_data,
  output logic                    busy,
  input  logic                    out_ready,
  output logic                    o_v0,
  output logic                    o_v1,
  output logic                    o_fast0,
  output logic [IW-1:0]           o_off0,
  output logic [IW-1:0]           o_off1,
  output logic [1:0]              o_len0,
  output logic [1:0]              o_len1,
  output logic [INS_W-1:0]        o_ins0,
  output logic [INS_W-1:0]        o_ins1
);
  logic                    run;
  logic [PW-1:0]           ptr;
  logic [LINE_BYTES-1:0]   mark;
  logic [2*LINE_BYTES-1:0] mlen;

  logic             m0, h0, h1, x1;
  logic [1:0]       code0, len0, len1, s_len;
  logic [PW-1:0]    q, nxt;
  logic [INS_W-1:0] ins0, ins1, ins_s;
  logic             s_busy, s_done;

  logic adv, at_end, s_start, s_finish, f_emit, miss0, clr_en;
  logic [IW-1:0] clr_idx;

  assign adv      = !o_v0 || out_ready;
  assign at_end   = (ptr >= PW'(LINE_BYTES));
  assign s_start  = run && !at_end && !s_busy && !h0;
  assign miss0    = s_start && m0;
  assign s_finish = s_done && adv;
  assign f_emit   = run && !at_end && !s_busy && h0 && adv;
  assign clr_en   = miss0 || (f_emit && x1);
  assign clr_idx  = miss0 ? ptr[IW-1:0] : q[IW-1:0];
  assign busy     = run;

  idec_marks #(.ENTRIES(LINE_BYTES)) u_marks (
    .clk(clk), .rst(rst), .clr_all(flush),
    .set_en(s_finish), .set_idx(ptr[IW-1:0]), .set_len(s_len),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .mark(mark), .mlen(mlen)
  );

  idec_fast #(.N(LINE_BYTES)) u_fast (
    .line(line_data), .ptr(ptr), .mark(mark), .mlen(mlen), .slen(s_len),
    .code0(code0), .m0(m0), .h0(h0), .h1(h1), .x1(x1),
    .len0(len0), .len1(len1), .q(q), .nxt(nxt),
    .ins0(ins0), .ins1(ins1), .ins_s(ins_s)
  );

  idec_slow u_slow (
    .clk(clk), .rst(rst), .start(s_start), .finish(s_finish),
    .code(code0), .busy(s_busy), .done(s_done), .len(s_len)
  );

  // Walk control: byte pointer advances only when the output stage loads.
  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      ptr <= '0;
    end else if (!run) begin
      if (start) begin
        run <= 1'b1;
        ptr <= '0;
      end
    end else if (at_end && !s_busy) begin
      run <= 1'b0;
    end else if (s_finish) begin
      ptr <= ptr + PW'(s_len);
    end else if (f_emit) begin
      ptr <= h1 ? nxt : q;
    end
  end

  // Registered two-slot output stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      o_v0    <= 1'b0;
      o_v1    <= 1'b0;
      o_fast0 <= 1'b0;
      o_off0  <= '0;
      o_off1  <= '0;
      o_len0  <= '0;
      o_len1  <= '0;
      o_ins0  <= '0;
      o_ins1  <= '0;
    end else if (adv) begin
      o_v0    <= s_finish || f_emit;
      o_v1    <= f_emit && h1;
      o_fast0 <= f_emit;
      if (s_finish) begin
        o_off0 <= ptr[IW-1:0];
        o_len0 <= s_len;
        o_ins0 <= ins_s;
      end else if (f_emit) begin
        o_off0 <= ptr[IW-1:0];
        o_len0 <= len0;
        o_ins0 <= ins0;
        o_off1 <= q[IW-1:0];
        o_len1 <= len1;
        o_ins1 <= ins1;
      end
    end
  end
endmodule

// File: rtl/idec_dual_chk.sv
module idec_dual_chk import idec_pkg::*; #(
  parameter  int LINE_BYTES = 16,
  localparam int IW = $clog2(LINE_BYTES)
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             out_ready,
  input logic             o_v0,
  input logic             o_v1,
  input logic             o_fast0,
  input logic [IW-1:0]    o_off0,
  input logic [IW-1:0]    o_off1,
  input logic [1:0]       o_len0,
  input logic [INS_W-1:0] o_ins0,
  input logic [INS_W-1:0] o_ins1
);
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  p_len_code_r1: assert property (@(posedge clk) disable iff (rst)
    o_v0 |-> (o_len0 == len_of(o_ins0[1:0])));

  p_pad_r1: assert property (@(posedge clk) disable iff (rst)
    (o_v0 && o_len0 == 2'd1) |-> (o_ins0[INS_W-1:8] == '0));

  p_contig_r5: assert property (@(posedge clk) disable iff (rst)
    o_v1 |-> ({1'b0, o_off1} == ({1'b0, o_off0} + (IW+1)'(o_len0))));

  p_pair_order_r6: assert property (@(posedge clk) disable iff (rst)
    o_v1 |-> (o_v0 && o_fast0));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (o_v0 && !out_ready) |=> (o_v0 && $stable(o_v1) && $stable(o_off0) &&
                              $stable(o_ins0) && $stable(o_ins1) && $stable(o_fast0)));
endmodule

bind idec_dual idec_dual_chk #(.LINE_BYTES(LINE_BYTES)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .out_ready(out_ready),
  .o_v0(o_v0), .o_v1(o_v1), .o_fast0(o_fast0), .o_off0(o_off0), .o_off1(o_off1),
  .o_len0(o_len0), .o_ins0(o_ins0), .o_ins1(o_ins1)
);

// File: tb/idec_dual_test.sv
module idec_dual_test;
  localparam int LB = 16;
  localparam int IW = $clog2(LB);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst = 1'b1, flush = 1'b0, start = 1'b0, out_ready = 1'b1;
  logic [8*LB-1:0] line_data = '0;
  logic            busy, o_v0, o_v1, o_fast0;
  logic [IW-1:0]   o_off0, o_off1;
  logic [1:0]      o_len0, o_len1;
  logic [23:0]     o_ins0, o_ins1;

  idec_dual #(.LINE_BYTES(LB)) uut (
    .clk(clk), .rst(rst), .flush(flush), .start(start), .line_data(line_data),
    .busy(busy), .out_ready(out_ready), .o_v0(o_v0), .o_v1(o_v1), .o_fast0(o_fast0),
    .o_off0(o_off0), .o_off1(o_off1), .o_len0(o_len0), .o_len1(o_len1),
    .o_ins0(o_ins0), .o_ins1(o_ins1)
  );

  typedef struct { int off; int len; logic [23:0] ins; bit fast; int slot; } exp_t;
  exp_t eq[$];

  bit  mk[LB];
  int  ml[LB];
  int  n_tests = 0, n_fail = 0, cyc = 0, last_evt = 0;
  bit  bp_mode = 0, finished = 0;
  int unsigned seed = 32'h1234_5678;

  bit          prev_stall = 0, sv_v1;
  logic [IW-1:0] sv_off0;
  logic [23:0] sv_ins0, sv_ins1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lenc(input logic [7:0] b);
    return (b[1:0] == 2'd3) ? 3 : (b[1:0] == 2'd2) ? 2 : 1;
  endfunction

  task automatic next_rand(output int unsigned r);
    seed = seed * 32'd1103515245 + 32'd12345;
    r = seed;
  endtask

  task automatic build(input int lens[16], output logic [8*LB-1:0] ln);
    int p;
    int unsigned r;
    logic [7:0] b;
    ln = '0;
    p = 0;
    for (int k = 0; k < 16 && lens[k] != 0; k++) begin
      for (int j = 0; j < lens[k]; j++) begin
        next_rand(r);
        b = r[23:16];
        if (j == 0) b[1:0] = (lens[k] == 3) ? 2'd3 : (lens[k] == 2) ? 2'd2 : (r[9] ? 2'd0 : 2'd1);
        ln[(p+j)*8 +: 8] = b;
      end
      p += lens[k];
    end
  endtask

  task automatic rand_lens(output int lens[16]);
    int rem, l;
    int unsigned r;
    rem = LB;
    for (int k = 0; k < 16; k++) begin
      if (rem > 0) begin
        next_rand(r);
        l = 1 + int'(r[20:12] % 3);
        if (l > rem) l = rem;
        lens[k] = l;
        rem -= l;
      end else lens[k] = 0;
    end
  endtask

  // Driver side: reference walk of the line, pushing expected slot items.
  task automatic plan(input logic [8*LB-1:0] ln);
    int offs[16], lns[16];
    bit fs[16];
    int n, p, i;
    exp_t e;
    n = 0; p = 0;
    while (p < LB) begin
      lns[n]  = lenc(ln[p*8 +: 8]);
      offs[n] = p;
      fs[n]   = mk[p] && (ml[p] == lns[n]);
      mk[p]   = 1;
      ml[p]   = lns[n];
      p      += lns[n];
      n++;
    end
    i = 0;
    while (i < n) begin
      for (int s = 0; s < 2; s++) begin
        if (s == 0 || (fs[i-1] && i < n && fs[i] && e.slot == 0)) begin
          e.off = offs[i]; e.len = lns[i]; e.fast = fs[i]; e.slot = s;
          e.ins = '0;
          for (int k = 0; k < lns[i]; k++) e.ins[k*8 +: 8] = ln[(offs[i]+k)*8 +: 8];
          eq.push_back(e);
          i++;
        end
      end
    end
  endtask

  task automatic take(input int s, input int off, input int len, input logic [23:0] ins, input bit fast);
    exp_t e;
    if (eq.size() == 0) begin
      chk(0, "R2", "output with nothing expected", off, -1);
      return;
    end
    e = eq.pop_front();
    chk(e.slot == s, "R5 R6 R7", "slot position", s, e.slot);
    chk(off == e.off, "R1", "offset", off, e.off);
    chk(len == e.len, "R1", "length", len, e.len);
    chk(ins == e.ins, "R1", "bytes", int'(ins), int'(e.ins));
    chk(fast == e.fast, "R4 R8 R10", "path", fast, e.fast);
    if (!bp_mode && s == 0 && !e.fast)
      chk(cyc - last_evt == 3, "R3", "slow spacing", cyc - last_evt, 3);
  endtask

  // Monitor / scoreboard consumer.
  always @(negedge clk) begin
    bit r;
    if (!rst && !finished) begin
      r = bp_mode ? ($urandom % 3 != 0) : 1'b1;
      if (prev_stall)
        chk(o_v0 && o_v1 == sv_v1 && o_off0 == sv_off0 && o_ins0 == sv_ins0 && o_ins1 == sv_ins1,
            "R9", "held slots", int'(o_ins0), int'(sv_ins0));
      if (o_v0 && r) begin
        take(0, int'(o_off0), int'(o_len0), o_ins0, o_fast0);
        if (o_v1) take(1, int'(o_off1), int'(o_len1), o_ins1, 1'b1);
        if (!bp_mode) last_evt = cyc;
      end
      prev_stall = o_v0 && !r;
      sv_v1 = o_v1; sv_off0 = o_off0; sv_ins0 = o_ins0; sv_ins1 = o_ins1;
      out_ready = r;
    end
  end

  task automatic run_pass(input logic [8*LB-1:0] ln, input bit bp, input bit poke);
    @(negedge clk);
    line_data = ln;
    bp_mode   = bp;
    plan(ln);
    start     = 1'b1;
    last_evt  = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      chk(busy == 1'b1, "R2", "busy during walk", busy, 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy || eq.size() > 0 || o_v0) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(eq.size() == 0 && !busy && !o_v0, "R2", "walk complete and idle", eq.size(), 0);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int k = 0; k < LB; k++) mk[k] = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int la[16] = '{1,2,3,1,1,3,2,3,0,0,0,0,0,0,0,0};
    int lb[16] = '{1,2,2,1,1,3,3,3,0,0,0,0,0,0,0,0};
    int lc[16] = '{1,2,3,2,1,1,1,1,2,2,0,0,0,0,0,0};
    int lr[16];
    logic [8*LB-1:0] line_a, line_b, line_c, line_r;
    for (int k = 0; k < LB; k++) begin mk[k] = 0; ml[k] = 0; end
    build(la, line_a);
    build(lb, line_b);
    build(lc, line_c);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !o_v0 && !o_v1, "R2", "reset state", int'({busy, o_v0, o_v1}), 0);

    run_pass(line_a, 0, 0);   // first encounter: slow path only (R3)
    run_pass(line_a, 0, 0);   // learned: fast, paired (R4 R5)
    run_pass(line_b, 0, 0);   // changed lengths at learned offsets (R7 R8)
    run_pass(line_c, 0, 0);
    run_pass(line_a, 0, 0);
    for (int t = 0; t < 6; t++) begin
      rand_lens(lr);
      build(lr, line_r);
      run_pass(line_r, t[0], 0);
      run_pass(line_r, !t[0], 0);
    end
    run_pass(line_a, 1, 0);   // backpressure (R9)
    run_pass(line_a, 0, 1);   // start while busy ignored (R2)
    do_flush();               // forget everything (R10)
    run_pass(line_a, 0, 0);
    run_pass(line_a, 0, 0);
    summary();
  end
endmodule